// File: doc/BRIEF.md
# Hypercube Dimension-Order Router with Two-Leg Mode

This block makes the routing decision for one node of a DIM-dimensional binary hypercube. Each cycle it can accept one packet header and return, one cycle later, the outgoing link and the updated header. The inputs are the node's own address and the header fields: final destination, intermediate address and leg bit. Two nodes are linked when their addresses differ in exactly one bit. The router always corrects the lowest differing address bit first. This ordering prevents cyclic channel dependencies, so routing cannot deadlock.

A packet can optionally travel in two legs to spread out hot spots. A header that enters the network here and asks for this mode gets an intermediate node from a free-running linear feedback shift register. The packet first travels to that node as leg 0 on virtual channel 0. When it reaches the intermediate node, the header switches to leg 1. It then continues by the same lowest-dimension-first rule toward the real destination on virtual channel 1. A packet that has reached its final destination leaves through the local ejection port.

One block instance serves every node: the `node_addr` port selects which node it acts as. Headers move through a single registered output stage with valid/ready handshaking.

Top module: `hcube_dimorder_router`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `out_valid` is 0 and `in_ready` is 1. The intermediate-address generator restarts from the value 1.
- R2: When the packet must still move, `out_local` is 0 and `out_dim` is the index of the lowest set bit of `node_addr` XOR target.
- R3: For a non-fresh header, the target is `in_mid` when the leg bit is 0 and `in_dst` when the leg bit is 1.
- R4: A leg-0 header whose intermediate address equals `node_addr` leaves with `out_leg`=1. It is routed toward `in_dst`, and it goes to the local port if `node_addr` also equals `in_dst`.
- R5: A leg-1 header with `node_addr` equal to `in_dst` leaves with `out_local`=1, `out_dim`=0 and `out_leg`=1.
- R6: `out_vc` equals `out_leg`: 0 on the first leg and 1 on the second.
- R7: A fresh header (`in_fresh`=1) with `in_twophase`=0 leaves with leg 1 and `out_mid` equal to `in_dst`. The value on `in_mid` is ignored.
- R8: A fresh header with `in_twophase`=1 leaves with leg 0 and `out_mid` equal to the generator state s. Accepting it advances the generator to (s>>1) XOR (s[0] ? 3'b110 : 0) for DIM=3, giving the sequence 1,6,3,7,5,4,2. No other event moves the generator.
- R9: `in_ready` is 1 exactly when the output stage is empty or `out_ready` is 1. While `out_valid` is 1 and `out_ready` is 0, every output holds its value.
- R10: When a packet is walked hop by hop from any source, each hop moves along one dimension in which the current node differs from the current target. The leg never returns from 1 to 0. Within a leg, the dimensions strictly increase. The packet reaches the local port at its destination within 2*DIM hops.
- R11: For a non-fresh header, `in_twophase` has no effect on the output or on the generator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| node_addr | input | DIM | Address of the node the decision is made for |
| in_valid | input | 1 | Header offered |
| in_ready | output | 1 | Header accepted when high together with in_valid |
| in_fresh | input | 1 | Header is being injected at this node |
| in_twophase | input | 1 | Fresh header requests the two-leg route |
| in_dst | input | DIM | Final destination address |
| in_mid | input | DIM | Intermediate address carried in the header |
| in_leg | input | 1 | Leg bit carried in the header |
| out_ready | input | 1 | Downstream takes the registered result |
| out_valid | output | 1 | Registered result present |
| out_local | output | 1 | Deliver to the local port |
| out_dim | output | DW | Dimension link to leave on (0 when local) |
| out_vc | output | 1 | Virtual channel class |
| out_dst | output | DIM | Destination carried forward |
| out_mid | output | DIM | Intermediate address carried forward |
| out_leg | output | 1 | Leg bit carried forward |

## Verification
Several properties are checked on every cycle:
- the output registers hold steady while stalled;
- a leg-0 result is never a local delivery;
- a local result always carries dimension 0 on leg 1;
- the chosen dimension is a differing bit with no lower differing bit;
- the intermediate-address generator never reaches zero, and moves only when told to.

Other behaviours only the bench scenarios can show. These are that every source and destination pair actually arrives, that dimensions increase within each leg across a whole route, and that the generator's output sequence lands in the headers. They also include that a header held back by a stall is not consumed and does not advance the generator.

// File: rtl/hcr_pkg.sv
`timescale 1ns/1ps
package hcr_pkg;

  // Feedback mask for a right-shifting Galois register of width w.
  function automatic logic [31:0] lfsr_taps(input int w);
    case (w)
      2:       return 32'h3;
      3:       return 32'h6;
      4:       return 32'hC;
      5:       return 32'h14;
      6:       return 32'h30;
      7:       return 32'h60;
      8:       return 32'hB8;
      default: return (32'h1 << (w - 1)) | (32'h1 << (w - 2));
    endcase
  endfunction

  function automatic int dim_bits(input int d);
    return (d > 1) ? $clog2(d) : 1;
  endfunction

endpackage

// File: rtl/hcr_lfsr.sv
`timescale 1ns/1ps
module hcr_lfsr #(
  parameter int           W    = 3,
  parameter logic [W-1:0] SEED = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  output logic [W-1:0] state
);
  localparam logic [W-1:0] TAPS = W'(hcr_pkg::lfsr_taps(W));

  always_ff @(posedge clk) begin
    if (rst)       state <= SEED;
    else if (step) state <= (state >> 1) ^ (state[0] ? TAPS : '0);
  end

  // R8: intermediate addresses come from a register that never locks at zero
  a_r8_never_zero: assert property (@(posedge clk) disable iff (rst)
    state != '0);
  // R8: state only moves on an accepted fresh two-leg header
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(state));
  a_r8_moves_on_step: assert property (@(posedge clk) disable iff (rst)
    step |=> state != $past(state));
endmodule

// File: rtl/hcr_lowbit.sv
`timescale 1ns/1ps
module hcr_lowbit #(
  parameter int W  = 3,
  parameter int IW = 2
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          any
);
  // found[i] is set when some bit below i is set
  logic [W:0] found;
  assign found[0] = 1'b0;

  for (genvar g = 0; g < W; g++) begin : g_chain
    assign found[g+1] = found[g] | vec[g];
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (vec[i] && !found[i]) idx = IW'(i);
    end
  end

  assign any = found[W];
endmodule

// File: rtl/hcr_decide.sv
`timescale 1ns/1ps
module hcr_decide #(
  parameter int DIM = 3,
  parameter int DW  = 2
) (
  input  logic [DIM-1:0] node,
  input  logic [DIM-1:0] dst,
  input  logic [DIM-1:0] mid,
  input  logic [DIM-1:0] rnd,
  input  logic           leg,
  input  logic           fresh,
  input  logic           twophase,
  output logic [DIM-1:0] o_mid,
  output logic [DIM-1:0] diff,
  output logic           o_leg,
  output logic           o_local,
  output logic           take_rnd,
  output logic [DW-1:0]  o_dim
);
  logic           leg_in;
  logic [DIM-1:0] tgt;
  logic           moving;

  always_comb begin
    take_rnd = fresh && twophase;
    if (fresh) begin
      o_mid  = twophase ? rnd : dst;
      leg_in = !twophase;
    end else begin
      o_mid  = mid;
      leg_in = leg;
    end
    // first leg complete here: rewrite into the second leg
    o_leg = leg_in | (o_mid == node);
    tgt   = o_leg ? dst : o_mid;
    diff  = node ^ tgt;
  end

  hcr_lowbit #(.W(DIM), .IW(DW)) u_low (
    .vec (diff),
    .idx (o_dim),
    .any (moving)
  );

  assign o_local = !moving;
endmodule

// File: rtl/hcube_dimorder_router.sv
`timescale 1ns/1ps
module hcube_dimorder_router #(
  parameter int DIM  = 3,
  parameter int SEED = 1,
  localparam int DW  = hcr_pkg::dim_bits(DIM)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [DIM-1:0] node_addr,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic           in_fresh,
  input  logic           in_twophase,
  input  logic [DIM-1:0] in_dst,
  input  logic [DIM-1:0] in_mid,
  input  logic           in_leg,
  input  logic           out_ready,
  output logic           out_valid,
  output logic           out_local,
  output logic [DW-1:0]  out_dim,
  output logic           out_vc,
  output logic [DIM-1:0] out_dst,
  output logic [DIM-1:0] out_mid,
  output logic           out_leg
);
  logic           accept;
  logic [DIM-1:0] rnd;
  logic [DIM-1:0] d_mid;
  logic [DIM-1:0] d_diff;
  logic           d_leg;
  logic           d_local;
  logic           d_take;
  logic [DW-1:0]  d_dim;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  hcr_lfsr #(.W(DIM), .SEED(DIM'(SEED))) u_rng (
    .clk   (clk),
    .rst   (rst),
    .step  (accept && d_take),
    .state (rnd)
  );

  hcr_decide #(.DIM(DIM), .DW(DW)) u_dec (
    .node     (node_addr),
    .dst      (in_dst),
    .mid      (in_mid),
    .rnd      (rnd),
    .leg      (in_leg),
    .fresh    (in_fresh),
    .twophase (in_twophase),
    .o_mid    (d_mid),
    .diff     (d_diff),
    .o_leg    (d_leg),
    .o_local  (d_local),
    .take_rnd (d_take),
    .o_dim    (d_dim)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_local <= 1'b0;
      out_dim   <= '0;
      out_dst   <= '0;
      out_mid   <= '0;
      out_leg   <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_local <= d_local;
      out_dim   <= d_dim;
      out_dst   <= in_dst;
      out_mid   <= d_mid;
      out_leg   <= d_leg;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // the virtual-channel class follows the leg
  assign out_vc = out_leg;

  // R9: stalled result is held unchanged
  a_r9_stall_hold: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid &&
      $stable({out_local, out_dim, out_dst, out_mid, out_leg}));
  // R4: a leg-0 result never delivers locally
  a_r4_leg0_moves: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_leg |-> !out_local);
  // R5: local delivery is on leg 1 with dimension 0
  a_r5_local_form: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_local |-> out_leg && out_dim == '0);
  // R2: chosen dimension differs and no lower dimension differs
  a_r2_lowest_dim: assert property (@(posedge clk) disable iff (rst)
    in_valid && !d_local |->
      d_diff[d_dim] && ((d_diff & ((DIM'(1) << d_dim) - DIM'(1))) == '0));
endmodule

// File: tb/hcube_dimorder_router_tb_top.sv
`timescale 1ns/1ps
module hcube_dimorder_router_tb_top;
  localparam int DIM = 3;
  localparam int DW  = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DIM-1:0] node_addr = '0;
  logic in_valid = 1'b0, in_fresh = 1'b0, in_twophase = 1'b0, in_leg = 1'b0;
  logic [DIM-1:0] in_dst = '0, in_mid = '0;
  logic out_ready = 1'b1;
  logic in_ready, out_valid, out_local, out_vc, out_leg;
  logic [DW-1:0] out_dim;
  logic [DIM-1:0] out_dst, out_mid;

  always #4 clk = ~clk;

  hcube_dimorder_router #(.DIM(DIM)) dut_i (
    .clk(clk), .rst(rst), .node_addr(node_addr),
    .in_valid(in_valid), .in_ready(in_ready), .in_fresh(in_fresh),
    .in_twophase(in_twophase), .in_dst(in_dst), .in_mid(in_mid),
    .in_leg(in_leg), .out_ready(out_ready), .out_valid(out_valid),
    .out_local(out_local), .out_dim(out_dim), .out_vc(out_vc),
    .out_dst(out_dst), .out_mid(out_mid), .out_leg(out_leg)
  );

  int n_cmp = 0, n_bad = 0;
  bit fin = 0;
  int t_rnd = 1;

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int lnext(input int s);
    return (s >> 1) ^ (((s & 1) != 0) ? 6 : 0);
  endfunction

  // ---------------- behavioural reference model ----------------
  int m_valid = 0, m_local = 0, m_dim = 0, m_dst = 0, m_mid = 0, m_leg = 0;
  int m_lfsr = 1;

  task automatic mroute(input int node, input int fresh, input int tp,
                        input int dst, input int mid, input int leg, input int rnd,
                        output int omid, output int oleg, output int oloc, output int odim);
    int x;
    omid = fresh ? (tp ? rnd : dst) : mid;
    oleg = fresh ? (tp ? 0 : 1) : leg;
    if (oleg == 0 && omid == node) oleg = 1;
    x = node ^ (oleg ? dst : omid);
    oloc = (x == 0);
    odim = 0;
    for (int i = DIM - 1; i >= 0; i--) if (((x >> i) & 1) != 0) odim = i;
  endtask

  always @(posedge clk) begin
    int a, b, c, d;
    if (rst) begin
      m_valid = 0; m_lfsr = 1;
    end else if (in_valid && (m_valid == 0 || out_ready)) begin
      mroute(int'(node_addr), int'(in_fresh), int'(in_twophase), int'(in_dst),
             int'(in_mid), int'(in_leg), m_lfsr, a, b, c, d);
      m_valid = 1; m_mid = a; m_leg = b; m_local = c; m_dim = d; m_dst = int'(in_dst);
      if (in_fresh && in_twophase) m_lfsr = lnext(m_lfsr);
    end else if (out_ready) begin
      m_valid = 0;
    end
  end

  always @(negedge clk) begin
    int act, exp;
    if (!rst && !fin) begin
      act = {out_valid, in_ready};
      exp = {m_valid[0], (m_valid == 0) || out_ready};
      if (m_valid != 0) begin
        act = (act << 12) | {out_local, out_dim, out_vc, out_dst, out_mid, out_leg};
        exp = (exp << 12) | {m_local[0], m_dim[1:0], m_leg[0], m_dst[2:0], m_mid[2:0], m_leg[0]};
      end
      chk("R2/R9 cycle model", act, exp);
    end
  end

  // ---------------- stimulus helpers ----------------
  int r_local, r_dim, r_vc, r_mid, r_leg, r_valid;

  task automatic xfer(input int node, input bit fresh, input bit tp,
                      input int dst, input int mid, input bit leg);
    @(negedge clk);
    node_addr = DIM'(node); in_fresh = fresh; in_twophase = tp;
    in_dst = DIM'(dst); in_mid = DIM'(mid); in_leg = leg; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    r_valid = out_valid; r_local = out_local; r_dim = out_dim; r_vc = out_vc;
    r_mid = out_mid; r_leg = out_leg;
  endtask

  task automatic walk(input int src, input int dst, input bit tp);
    int node = src, mid = 0, leg = 0, last_dim = -1, prev_leg = 0, hops = 0;
    bit fresh = 1, arrived = 0;
    while (!arrived && hops <= 2 * DIM) begin
      xfer(node, fresh, tp, dst, mid, leg[0]);
      if (fresh && tp) begin
        chk("R8 walk intermediate", r_mid, t_rnd);
        t_rnd = lnext(t_rnd);
      end
      if (!fresh && r_leg < prev_leg) chk("R10 leg went back", r_leg, prev_leg);
      if (r_local != 0) begin
        chk("R10 arrival node", node, dst);
        arrived = 1;
      end else begin
        if (!fresh && r_leg == prev_leg && r_dim <= last_dim)
          chk("R10 dimension order", r_dim, last_dim + 1);
        if (r_leg != prev_leg) last_dim = -1;
        chk("R10 hop on differing bit",
            ((node ^ (r_leg ? dst : r_mid)) >> r_dim) & 1, 1);
        last_dim = r_dim; prev_leg = r_leg;
        node = node ^ (1 << r_dim);
        mid = r_mid; leg = r_leg; fresh = 0; hops++;
      end
    end
    chk("R10 arrived within 2*DIM hops", arrived, 1);
  endtask

  task automatic finish_run();
    fin = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired before completion");
      finish_run();
    end
  end

  initial begin
    int a_mid, a_dim;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 out_valid in reset", out_valid, 0);
    chk("R1 in_ready in reset", in_ready, 1);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 out_valid after reset", out_valid, 0);

    // R2, R5, R7: route 010 -> 111 step by step
    xfer(2, 1, 0, 7, 5, 0);
    chk("R2 first dim", r_dim, 0);
    chk("R7 mid equals dst", r_mid, 7);
    chk("R7 leg 1", r_leg, 1);
    xfer(3, 0, 0, 7, 7, 1);
    chk("R2 second dim", r_dim, 2);
    xfer(7, 0, 0, 7, 7, 1);
    chk("R5 local", r_local, 1);
    chk("R5 dim zero", r_dim, 0);
    chk("R6 vc on leg 1", r_vc, 1);

    // R3: target chosen by leg
    xfer(0, 0, 0, 1, 6, 0);
    chk("R3 leg0 targets mid", r_dim, 1);
    chk("R6 vc on leg 0", r_vc, 0);
    xfer(0, 0, 0, 1, 6, 1);
    chk("R3 leg1 targets dst", r_dim, 0);

    // R4: first leg completes at the intermediate node
    xfer(6, 0, 0, 5, 6, 0);
    chk("R4 rewritten leg", r_leg, 1);
    chk("R4 toward dst", r_dim, 0);
    xfer(5, 0, 0, 5, 5, 0);
    chk("R4 mid equals dst local", r_local, 1);

    // R11: tp ignored on non-fresh header, generator untouched
    xfer(0, 0, 1, 3, 3, 1);
    chk("R11 non-fresh tp dim", r_dim, 0);
    chk("R11 non-fresh tp leg", r_leg, 1);
    // R8: fresh two-leg headers take successive generator values
    xfer(0, 1, 1, 0, 0, 0);
    chk("R8 first value", r_mid, t_rnd);
    chk("R8 leg 0", r_leg, 0);
    t_rnd = lnext(t_rnd);
    xfer(4, 1, 1, 4, 0, 0);
    chk("R8 second value", r_mid, t_rnd);
    chk("R8 second dim", r_dim, 1);
    t_rnd = lnext(t_rnd);
    // R8 boundary: intermediate equals this node
    xfer(3, 1, 1, 0, 0, 0);
    chk("R8 mid at node", r_mid, 3);
    chk("R4 immediate leg switch", r_leg, 1);
    chk("R4 immediate dim", r_dim, 0);
    t_rnd = lnext(t_rnd);

    // R9: backpressure holds output, second header not consumed
    @(negedge clk);
    out_ready = 1'b0;
    node_addr = 0; in_fresh = 1; in_twophase = 1; in_dst = 5; in_leg = 0; in_valid = 1;
    @(negedge clk);
    chk("R9 first accepted", out_valid, 1);
    a_mid = out_mid; a_dim = out_dim;
    chk("R8 stalled header mid", a_mid, t_rnd);
    t_rnd = lnext(t_rnd);
    node_addr = 1; in_dst = 2;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R9 in_ready low while stalled", in_ready, 0);
      chk("R9 mid held", out_mid, a_mid);
      chk("R9 dim held", out_dim, a_dim);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 0;
    chk("R9 second header mid", out_mid, t_rnd);
    t_rnd = lnext(t_rnd);

    // R10: every pair by direct route, then two-leg routes
    for (int s = 0; s < (1 << DIM); s++)
      for (int d = 0; d < (1 << DIM); d++)
        walk(s, d, 0);
    for (int s = 0; s < (1 << DIM); s++) begin
      walk(s, (s * 3 + 1) % (1 << DIM), 1);
      walk(s, s, 1);
    end

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule